// File: doc/BRIEF.md
# Four-Stage Pipelined 16-Bit Integer Core

This block is a small processor core for a 16-bit, word-addressed instruction set, covering only the integer instructions. Every instruction word splits into three fields: an operation code in bits 15:12, a destination register number in bits 11:6 and a source register number in bits 5:0. Together they address 64 general registers of 16 bits each. Instructions and data share one internal memory of 2^MEM_AW words. Addresses wider than the memory wrap modulo its depth.

The pipeline has four stages: fetch, register read, execute (ALU or data memory) and write-back. A two-word immediate load is fetched in a single slot, because fetch reads the word at the PC and the word after it together. Results in the execute and write-back stages are forwarded to the register-read stage, so no data hazard needs a stall. A conditional jump or skip is resolved in the register-read stage. When its register is non-zero it costs nothing. When it is taken, the single younger slot already in fetch is squashed. A controller with three states governs the core. RUN_ACTIVE goes to RUN_DRAIN when a halting instruction is decoded, and fetch then stops. RUN_DRAIN goes to RUN_STOPPED when that instruction reaches write-back. RUN_STOPPED holds until reset.

A test program runs from address 0 after reset. It can check its own results by placing a halt at each failure point, so the PC where the core stops tells the bench whether the program passed.

Top module: `p16_core`

## Requirements
- R1: While reset is asserted, halt is 0 and pc_o is 0. After reset, registers 0, 1, 2 and 3 hold 0x0000, 0x0001, 0x8000 and 0xFFFF, and all other registers hold 0.
- R2: The ALU opcodes update register D (destination field) from register S (source field): 0x0 gives D+S; 0x4, 0x5 and 0x6 give D&S, D|S and D^S; 0x7 gives 1 if S is non-zero, else 0; 0x8 gives S; 0x9 gives S shifted right logically by one.
- R3: Opcode 0xC loads D from memory[S]. Opcode 0xD writes D to memory[S]. A load that follows a store to the same address returns the stored value.
- R4: Opcode 0xF writes the next memory word to D and continues execution two words later. That data word is never executed, whatever its value.
- R5: Opcode 0xE with source field 0 halts the core. Every older instruction completes first. Halt then rises exactly 4 cycles after the halting instruction's fetch slot and stays high until reset. While halted, pc_o holds the halting instruction's address plus 1.
- R6: Opcode 0xE with a source field of 2 or more is a jump. When D is zero, execution continues at the address held in S and the younger instruction already fetched is discarded. When D is non-zero, execution continues in sequence.
- R7: Opcode 0xE with source field 1 is a skip. When D is zero, the next instruction is passed over, and if that instruction is a two-word immediate load both of its words are passed over.
- R8: A jump or skip whose register is non-zero adds no cycle. A program of k fetch slots before its halt, with no taken jump or skip, shows halt high after k+4 clock edges. Each taken jump or skip adds exactly one slot.
- R9: An instruction that reads a register written by either of the two instructions just before it sees the new value, with no stall cycle.
- R10: The floating-point opcodes 0x1, 0x2, 0x3, 0xA and 0xB halt the core in the same way as the halt instruction, with the same pc_o value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| halt | output | 1 | High once the core has stopped |
| pc_o | output | 16 | Current fetch address; after a halt, the halting address plus 1 |

## Verification
The hardest situation to reach from the ports is a skip that lands on a two-word immediate load. Only the pairing in fetch decides whether one word or two are passed over, and the core's only outputs are halt and the PC. To reach it, the bench writes programs straight into the core's memory. One program places an immediate load whose data word decodes as a floating-point opcode directly after a taken skip. If the skip passed over only one word, the core would halt on the data word at a known, wrong PC. The bench also compares the number of cycles to halt against the slot count, which exposes any bubble inserted by forwarding, or by a jump or skip whose register is non-zero.

// File: rtl/p16_pkg.sv
package p16_pkg;

    localparam int WORD_W = 16;
    localparam int RIDX_W = 6;
    localparam int NREG   = 1 << RIDX_W;

    localparam logic [3:0] OPC_ADD = 4'h0;
    localparam logic [3:0] OPC_AND = 4'h4;
    localparam logic [3:0] OPC_OR  = 4'h5;
    localparam logic [3:0] OPC_XOR = 4'h6;
    localparam logic [3:0] OPC_ANY = 4'h7;
    localparam logic [3:0] OPC_DUP = 4'h8;
    localparam logic [3:0] OPC_SHR = 4'h9;
    localparam logic [3:0] OPC_LD  = 4'hC;
    localparam logic [3:0] OPC_ST  = 4'hD;
    localparam logic [3:0] OPC_CTL = 4'hE;
    localparam logic [3:0] OPC_LDI = 4'hF;

    localparam logic [5:0] SUB_HALT = 6'd0;
    localparam logic [5:0] SUB_SKIP = 6'd1;

    typedef enum logic [1:0] {
        RUN_ACTIVE,
        RUN_DRAIN,
        RUN_STOPPED
    } run_state_t;

    function automatic logic op_is_float(input logic [3:0] op);
        return (op == 4'h1) || (op == 4'h2) || (op == 4'h3) ||
               (op == 4'hA) || (op == 4'hB);
    endfunction

    function automatic logic op_writes_reg(input logic [3:0] op);
        return (op == OPC_ADD) || (op == OPC_AND) || (op == OPC_OR) ||
               (op == OPC_XOR) || (op == OPC_ANY) || (op == OPC_DUP) ||
               (op == OPC_SHR) || (op == OPC_LD)  || (op == OPC_LDI);
    endfunction

endpackage

// File: rtl/p16_mem.sv
module p16_mem #(
    parameter int AW = 10
) (
    input  logic        clk,
    input  logic [15:0] fa_addr,
    output logic [15:0] fa_word,
    input  logic [15:0] fb_addr,
    output logic [15:0] fb_word,
    input  logic [15:0] d_addr,
    output logic [15:0] d_rdata,
    input  logic        d_we,
    input  logic [15:0] d_wdata
);
    localparam int DEPTH = 1 << AW;

    logic [15:0] cells [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (d_we) cells[d_addr[AW-1:0]] <= d_wdata;
    end

    assign fa_word = cells[fa_addr[AW-1:0]];
    assign fb_word = cells[fb_addr[AW-1:0]];
    assign d_rdata = cells[d_addr[AW-1:0]];

endmodule

// File: rtl/p16_regfile.sv
module p16_regfile
    import p16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] ra_a,
    output logic [WORD_W-1:0] rd_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [WORD_W-1:0] rd_b,
    input  logic              we,
    input  logic [RIDX_W-1:0] wa,
    input  logic [WORD_W-1:0] wd
);
    logic [WORD_W-1:0] regs [0:NREG-1];

    function automatic logic [WORD_W-1:0] preset(input int idx);
        case (idx)
            1:       return WORD_W'(16'h0001);
            2:       return WORD_W'(16'h8000);
            3:       return WORD_W'(16'hFFFF);
            default: return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= preset(i);
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/p16_alu.sv
module p16_alu
    import p16_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] mrd,
    output logic [WORD_W-1:0] y
);
    always_comb begin
        case (op)
            OPC_ADD: y = a + b;
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_XOR: y = a ^ b;
            OPC_ANY: y = (b != '0) ? WORD_W'(1) : '0;
            OPC_DUP: y = b;
            OPC_SHR: y = b >> 1;
            OPC_LD:  y = mrd;
            OPC_LDI: y = b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/p16_core.sv
module p16_core
    import p16_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic        clk,
    input  logic        rst,
    output logic        halt,
    output logic [15:0] pc_o
);
    run_state_t st_q, st_d;

    logic [15:0] pc_q;
    logic [15:0] f_word, f_next, f_len;

    // fetch / register-read boundary
    logic        d_valid;
    logic [15:0] d_ir, d_imm, d_pc;
    logic [3:0]  d_op;
    logic [5:0]  d_dst, d_src;

    // register-read / execute boundary
    logic        x_we, x_st, x_halt;
    logic [3:0]  x_op;
    logic [5:0]  x_dst;
    logic [15:0] x_a, x_b;

    // execute / write-back boundary
    logic        w_we, w_halt;
    logic [5:0]  w_dst;
    logic [15:0] w_val;

    logic [15:0] rf_a, rf_b, dval, sval, ex_y, m_rd;
    logic        is_ctl, is_jump, is_skip, id_stop, jump_take, skip_take;

    p16_mem #(.AW(MEM_AW)) u_mem (
        .clk     (clk),
        .fa_addr (pc_q),
        .fa_word (f_word),
        .fb_addr (pc_q + 16'd1),
        .fb_word (f_next),
        .d_addr  (x_b),
        .d_rdata (m_rd),
        .d_we    (x_st),
        .d_wdata (x_a)
    );

    p16_regfile u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (d_dst),
        .rd_a (rf_a),
        .ra_b (d_src),
        .rd_b (rf_b),
        .we   (w_we),
        .wa   (w_dst),
        .wd   (w_val)
    );

    p16_alu u_alu (
        .op  (x_op),
        .a   (x_a),
        .b   (x_b),
        .mrd (m_rd),
        .y   (ex_y)
    );

    // fetch: an immediate load occupies one slot of two words
    assign f_len = (f_word[15:12] == OPC_LDI) ? 16'd2 : 16'd1;

    // decode
    assign d_op  = d_ir[15:12];
    assign d_dst = d_ir[11:6];
    assign d_src = d_ir[5:0];

    assign is_ctl  = (d_op == OPC_CTL);
    assign is_skip = is_ctl && (d_src == SUB_SKIP);
    assign is_jump = is_ctl && (d_src != SUB_HALT) && (d_src != SUB_SKIP);
    assign id_stop = d_valid && ((is_ctl && d_src == SUB_HALT) || op_is_float(d_op));

    // operand forwarding: execute result is newest, then write-back
    always_comb begin
        dval = rf_a;
        sval = rf_b;
        if (w_we && w_dst == d_dst) dval = w_val;
        if (w_we && w_dst == d_src) sval = w_val;
        if (x_we && x_dst == d_dst) dval = ex_y;
        if (x_we && x_dst == d_src) sval = ex_y;
    end

    assign jump_take = d_valid && is_jump && (dval == 16'd0);
    assign skip_take = d_valid && is_skip && (dval == 16'd0);

    // controller state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= RUN_ACTIVE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_ACTIVE:  if (id_stop) st_d = RUN_DRAIN;
            RUN_DRAIN:   if (w_halt)  st_d = RUN_STOPPED;
            RUN_STOPPED: st_d = RUN_STOPPED;
            default:     st_d = RUN_ACTIVE;
        endcase
    end

    // controller outputs
    always_comb begin
        halt = (st_q == RUN_STOPPED);
        pc_o = pc_q;
    end

    // program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= 16'd0;
        end else if (st_q == RUN_ACTIVE) begin
            if (id_stop)        pc_q <= d_pc + 16'd1;
            else if (jump_take) pc_q <= sval;
            else                pc_q <= pc_q + f_len;
        end
    end

    // fetch -> register read
    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid <= 1'b0;
        end else begin
            d_valid <= (st_q == RUN_ACTIVE) && !id_stop && !jump_take && !skip_take;
        end
        d_ir  <= f_word;
        d_imm <= f_next;
        d_pc  <= pc_q;
    end

    // register read -> execute
    always_ff @(posedge clk) begin
        if (rst) begin
            x_we   <= 1'b0;
            x_st   <= 1'b0;
            x_halt <= 1'b0;
        end else begin
            x_we   <= d_valid && op_writes_reg(d_op);
            x_st   <= d_valid && (d_op == OPC_ST);
            x_halt <= id_stop;
        end
        x_op  <= d_op;
        x_dst <= d_dst;
        x_a   <= dval;
        x_b   <= (d_op == OPC_LDI) ? d_imm : sval;
    end

    // execute -> write-back
    always_ff @(posedge clk) begin
        if (rst) begin
            w_we   <= 1'b0;
            w_halt <= 1'b0;
        end else begin
            w_we   <= x_we;
            w_halt <= x_halt;
        end
        w_dst <= x_dst;
        w_val <= ex_y;
    end

    // R5
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R5
    halt_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(pc_o));

    // R5
    halt_empty_chk: assert property (@(posedge clk) disable iff (rst)
        halt |-> (!d_valid && !x_we && !x_st));

    // R6
    jump_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RUN_ACTIVE && jump_take) |=> (pc_q == $past(sval) && !d_valid));

    // R7
    skip_squash_chk: assert property (@(posedge clk) disable iff (rst)
        skip_take |=> !d_valid);

    // R8
    jump_nobubble_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RUN_ACTIVE && d_valid && (is_jump || is_skip) && dval != 16'd0) |=> d_valid);

    // R4
    ldi_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == RUN_ACTIVE && !id_stop && !jump_take && f_word[15:12] == OPC_LDI)
        |=> (pc_q == $past(pc_q) + 16'd2));

endmodule

// File: tb/p16_core_test.sv
module p16_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEMW = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt;
    logic [15:0] pc_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] img [0:MEMW-1];
    int wp;

    p16_core #(.MEM_AW(10)) uut (
        .clk  (clk),
        .rst  (rst),
        .halt (halt),
        .pc_o (pc_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic [3:0] o, input int d, input int s);
        img[wp] = {o, 6'(d), 6'(s)};
        wp++;
    endtask

    task automatic ldi(input int d, input logic [15:0] v);
        op(4'hF, d, 0);
        img[wp] = v;
        wp++;
    endtask

    // self-check: halt here unless register r holds v
    task automatic chk_reg(input int r, input logic [15:0] v);
        ldi(60, v);
        op(4'h6, 60, r);
        op(4'hE, 60, 1);
        op(4'hE, 0, 0);
    endtask

    task automatic finish_prog(output int good_pc);
        good_pc = wp + 1;
        op(4'hE, 0, 0);
    endtask

    // load program, reset, run to halt; cycles counted from reset release
    task automatic run(input string req, input int exp_pc, input int exp_cyc);
        int cyc;
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < wp; i++) uut.u_mem.cells[i] = img[i];
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (cyc < 3000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halt) break;
        end
        check(halt == 1'b1, {req, " halt reached"}, int'(halt), 1);
        check(pc_o == 16'(exp_pc), {req, " halt pc"}, int'(pc_o), exp_pc);
        if (exp_cyc >= 0) check(cyc == exp_cyc, {req, " cycles to halt"}, cyc, exp_cyc);
    endtask

    task automatic t_alu;
        int g;
        wp = 0;
        // R1 preload values
        chk_reg(0, 16'h0000); chk_reg(1, 16'h0001);
        chk_reg(2, 16'h8000); chk_reg(3, 16'hFFFF);
        // R2 operations, R9 back-to-back use
        ldi(4, 16'h1003); op(4'h0, 4, 1);  chk_reg(4, 16'h1004);
        ldi(5, 16'h4321); ldi(6, 16'h1234); op(4'h4, 5, 6); chk_reg(5, 16'h0220);
        ldi(7, 16'h4321); op(4'h5, 6, 7);  chk_reg(6, 16'h5335);
        ldi(8, 16'h1234); op(4'h6, 7, 8);  chk_reg(7, 16'h5115);
        op(4'h7, 9, 8);   chk_reg(9, 16'h0001);
        ldi(10, 16'h0007); op(4'h7, 10, 0); chk_reg(10, 16'h0000);
        op(4'h8, 11, 2);  chk_reg(11, 16'h8000);
        ldi(12, 16'h8421); op(4'h9, 12, 12); chk_reg(12, 16'h4210);
        finish_prog(g);
        run("R1 R2 R9 alu program", g, -1);
    endtask

    task automatic t_mem;
        int g;
        wp = 0;
        ldi(13, 16'h0200); ldi(14, 16'h0042);
        op(4'hD, 14, 13); op(4'hC, 15, 13); chk_reg(15, 16'h0042);
        ldi(14, 16'hBEEF); op(4'hD, 14, 13); op(4'hC, 16, 13); op(4'h0, 16, 1);
        chk_reg(16, 16'hBEF0);
        finish_prog(g);
        run("R3 load store", g, -1);
    endtask

    task automatic t_ldi;
        int g;
        wp = 0;
        ldi(17, 16'hE000); chk_reg(17, 16'hE000);
        ldi(18, 16'hF000); ldi(19, 16'h2000);
        chk_reg(18, 16'hF000); chk_reg(19, 16'h2000);
        finish_prog(g);
        run("R4 immediate data not executed", g, -1);
    endtask

    task automatic t_jump;
        int g, p1, p2;
        wp = 0;
        ldi(18, 16'h0000); p1 = wp - 1;
        op(4'hE, 0, 18);              // jz r0 -> taken
        ldi(19, 16'hDEAD);            // must be discarded
        op(4'hE, 0, 0);
        img[p1] = 16'(wp);
        chk_reg(19, 16'h0000);
        ldi(20, 16'h0000); p2 = wp - 1;
        op(4'hE, 1, 20);              // jz r1 -> not taken
        ldi(21, 16'h0005);
        img[p2] = 16'(wp);
        chk_reg(21, 16'h0005);
        finish_prog(g);
        run("R6 jump taken and not taken", g, -1);
    endtask

    task automatic t_skip;
        int g;
        wp = 0;
        op(4'hE, 0, 1);               // sz r0 -> skip whole immediate load
        ldi(22, 16'h1111);            // data word is a float opcode if misread
        chk_reg(22, 16'h0000);
        ldi(24, 16'h0000);
        op(4'hE, 24, 1);              // tested register just written
        op(4'hE, 0, 0);
        op(4'hE, 1, 1);               // sz r1 -> not taken
        ldi(23, 16'h0007);
        chk_reg(23, 16'h0007);
        finish_prog(g);
        run("R7 skip over two-word load", g, -1);
    endtask

    task automatic t_nobubble;
        wp = 0;
        ldi(25, 16'h0009);
        op(4'hE, 25, 1);
        ldi(26, 16'h0000);
        op(4'hE, 25, 26);
        op(4'h8, 27, 25);
        op(4'hE, 0, 0);               // address 7
        run("R8 non-zero jump and skip", 8, 9);
    endtask

    task automatic t_jump_cycles;
        wp = 0;
        ldi(26, 16'h0005);
        op(4'hE, 0, 26);              // taken to 5
        op(4'h8, 27, 3);
        op(4'h8, 27, 3);
        op(4'hE, 0, 0);               // address 5
        run("R8 taken jump cost", 6, 7);
    endtask

    task automatic t_forward;
        int g;
        wp = 0;
        ldi(4, 16'h0003);
        op(4'h0, 4, 4); op(4'h0, 4, 4); op(4'h0, 4, 4);
        chk_reg(4, 16'h0018);
        finish_prog(g);
        run("R9 forwarding without stall", g, 12);
    endtask

    task automatic t_float_hold;
        logic [15:0] held;
        wp = 0;
        op(4'h8, 4, 1);
        img[wp] = 16'h2000; wp++;
        run("R10 float opcode halts", 2, 5);
        held = pc_o;
        repeat (10) @(negedge clk);
        check(halt == 1'b1, "R5 halt stays high", int'(halt), 1);
        check(pc_o == held, "R5 pc held while halted", int'(pc_o), int'(held));
    endtask

    task automatic t_drain;
        int g;
        wp = 0;
        ldi(5, 16'h0300); ldi(6, 16'h0077);
        op(4'hD, 6, 5);               // store just before halt
        finish_prog(g);
        run("R5 older store before halt", g, 7);
        wp = 0;
        ldi(5, 16'h0300); op(4'hC, 7, 5);
        chk_reg(7, 16'h0077);
        finish_prog(g);
        run("R5 stored value survived", g, -1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(halt == 1'b0, "R1 halt cleared by reset", int'(halt), 0);
        check(pc_o == 16'd0, "R1 pc zero in reset", int'(pc_o), 0);
    endtask

    initial begin
        for (int i = 0; i < MEMW; i++) uut.u_mem.cells[i] = 16'h0000;
        t_alu();
        t_mem();
        t_ldi();
        t_jump();
        t_skip();
        t_nobubble();
        t_jump_cycles();
        t_forward();
        t_float_hold();
        t_drain();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule